// File: doc/BRIEF.md
# Retransmit-Capable FIFO Buffer

This block is a first-in/first-out store of 9-bit words. The 9th bit lets a user carry a parity or control bit next to an 8-bit byte. A writer and a reader move words through the buffer with active-low strobes. The block keeps its own circular write and read positions, so no address ever crosses its boundary. Depth is a parameter and may be 256, 512 or 1024 words. Reads and writes may be issued at the same time.

Everything runs on one system clock. The block samples each strobe once and then detects its edges. Three active-low status outputs report an empty buffer, a buffer more than half full, and a full buffer. Each flag asserts on the leading (falling) edge of the strobe that causes it and releases on the trailing (rising) edge of the strobe that undoes it. An active-low retransmit pulse rewinds the read position to the first location, so the stored data can be read out again from the start. A write into a full buffer and a read from an empty buffer are dropped, and a sticky error output records them.

Top module: `fifo_rt`

## Requirements
- R1: While reset is low and after its release: emptyN is low, halfN and fullN are high, dValid and strobeErr are low, and dOut is zero.
- R2: Words leave in the order they were stored, all 9 bits intact. A strobe edge on an input takes effect at the second rising clock edge after the input changes.
- R3: A write stores the value that dIn holds when wrN rises, not the value it held when wrN fell.
- R4: An accepted read loads the oldest word into dOut on the falling edge of rdN. dOut then holds that word until the next accepted read. dValid is high from that load until the rise of rdN is seen.
- R5: emptyN goes low on the read fall that takes the last stored word. It goes high on the write rise that stores a word into an empty buffer.
- R6: fullN goes low on the write fall that claims the last free location. It goes high on the rise of an accepted read.
- R7: halfN goes low on a write fall that brings the occupancy above DEPTH/2, counting the pending write. It goes high on the rise of an accepted read once the occupancy is DEPTH/2 or less.
- R8: A write fall while fullN is low, and a read fall while emptyN is low, are ignored. They change no stored word, no position and no output data.
- R9: strobeErr goes high on any ignored strobe and stays high until reset.
- R10: A falling edge on rtN sets the read position to the first location and leaves the write position unchanged. All three flags are then recomputed from the new occupancy. This holds while no more than DEPTH words have been written since reset.
- R11: The write and read positions wrap past the last location, so more than DEPTH words can stream through in order.
- R12: A read and a write whose strobes fall and rise together both take effect: the read returns the oldest stored word and the write is appended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Master reset, active low, clears both positions and all flags |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| rtN | input | 1 | Retransmit strobe, active low, acts on its falling edge |
| dIn | input | WIDTH (9) | Write data, captured on the rise of wrN |
| dOut | output | WIDTH (9) | Registered read data |
| dValid | output | 1 | High while an accepted read strobe is held low |
| emptyN | output | 1 | Low when no word is stored |
| halfN | output | 1 | Low when more than half the depth is filled |
| fullN | output | 1 | Low when every location is claimed |
| strobeErr | output | 1 | Sticky flag for ignored reads or writes |

## Verification
The write data changes between the strobe fall and the strobe rise, which separates capture on the rise from capture on the fall. A full fill, followed by a partial drain, a rewind and a full drain, moves every flag across its threshold in both directions. Reading the first word again shows the rewind worked, and an empty buffer after exactly DEPTH reads shows the dropped write was never stored. A long stream of reads and writes issued together carries both positions round the ring more than twice, which checks wrap-around and concurrent access against order loss.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  // widest address the block supports (1024 words)
  localparam int ADDR_W = 10;

  // strobes issued by the control to the datapath for one clock
  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] wAddr;
    logic              re;
    logic [ADDR_W-1:0] rAddr;
  } memCtl_t;
endpackage

// File: rtl/fifo_rt_sample.sv
// Samples active-low strobes once and keeps the previous sample for edge detection.
module fifo_rt_sample #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] strobeN,
  output logic [N-1:0] nowLvl,
  output logic [N-1:0] prevLvl
);
  for (genvar i = 0; i < N; i++) begin : g_strobe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nowLvl[i]  <= 1'b1;
        prevLvl[i] <= 1'b1;
      end else begin
        nowLvl[i]  <= strobeN[i];
        prevLvl[i] <= nowLvl[i];
      end
    end
  end
endmodule

// File: rtl/fifo_rt_ctrl.sv
// Ring positions, strobe acceptance and the three status flags.
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrFall,
  input  logic    wrRise,
  input  logic    rdFall,
  input  logic    rdRise,
  input  logic    rtFall,
  output memCtl_t ctl,
  output logic    emptyN,
  output logic    halfN,
  output logic    fullN,
  output logic    dValid,
  output logic    strobeErr
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);

  logic [PW-1:0] wrPtr, rdPtr, wrPtrNx, rdPtrNx, occNx;
  logic wrPend, rdPend, wrPendNx;
  logic wrAcc, rdAcc, wrCommit, rdDone;

  always_comb begin
    wrAcc    = wrFall & fullN;
    rdAcc    = rdFall & emptyN & ~rtFall;
    wrCommit = wrRise & wrPend;
    rdDone   = rdRise & rdPend;
    wrPtrNx  = wrPtr + PW'(wrCommit);
    rdPtrNx  = rtFall ? '0 : rdPtr + PW'(rdAcc);
    wrPendNx = wrAcc | (wrPend & ~wrRise);
    // stored words plus a claimed but not yet written slot
    occNx    = (wrPtrNx - rdPtrNx) + PW'(wrPendNx);
  end

  always_comb begin
    ctl.we    = wrCommit;
    ctl.wAddr = ADDR_W'(wrPtr[AW-1:0]);
    ctl.re    = rdAcc;
    ctl.rAddr = ADDR_W'(rdPtr[AW-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      wrPend    <= 1'b0;
      rdPend    <= 1'b0;
      emptyN    <= 1'b0;
      halfN     <= 1'b1;
      fullN     <= 1'b1;
      strobeErr <= 1'b0;
    end else begin
      wrPtr  <= wrPtrNx;
      rdPtr  <= rdPtrNx;
      wrPend <= wrPendNx;
      rdPend <= rdAcc | (rdPend & ~rdRise);
      emptyN <= (wrPtrNx != rdPtrNx);
      if (rtFall) begin
        fullN <= (occNx != FULL_LVL);
        halfN <= !(occNx > HALF_LVL);
      end else begin
        if (wrAcc && occNx == FULL_LVL) fullN <= 1'b0;
        else if (rdDone)                fullN <= 1'b1;
        if (wrAcc && occNx > HALF_LVL)        halfN <= 1'b0;
        else if (rdDone && occNx <= HALF_LVL) halfN <= 1'b1;
      end
      if ((wrFall & ~fullN) | (rdFall & ~emptyN & ~rtFall)) strobeErr <= 1'b1;
    end
  end

  assign dValid = rdPend;
endmodule

// File: rtl/fifo_rt_data.sv
// Word storage, write-data sampling and the registered read port.
module fifo_rt_data
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  input  memCtl_t          ctl,
  output logic [WIDTH-1:0] dOut
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] dSamp;
  logic [AW-1:0]    wIdx, rIdx;
  logic             unusedAddr;

  assign wIdx       = ctl.wAddr[AW-1:0];
  assign rIdx       = ctl.rAddr[AW-1:0];
  assign unusedAddr = ^{ctl.wAddr, ctl.rAddr};

  // sampled in the same clock as the strobes, so data lines up with wrN
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dSamp <= '0;
    else       dSamp <= dIn;
  end

  always_ff @(posedge clk) begin
    if (ctl.we) store[wIdx] <= dSamp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       dOut <= '0;
    else if (ctl.re) dOut <= store[rIdx];
  end
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             rtN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut,
  output logic             dValid,
  output logic             emptyN,
  output logic             halfN,
  output logic             fullN,
  output logic             strobeErr
);
  localparam int N_STROBE = 3;
  localparam int S_WR = 0;
  localparam int S_RD = 1;
  localparam int S_RT = 2;

  logic [N_STROBE-1:0] nowLvl, prevLvl, fallV, riseV;
  memCtl_t ctl;

  fifo_rt_sample #(.N(N_STROBE)) u_sample (
    .clk(clk), .rstN(rstN), .strobeN({rtN, rdN, wrN}),
    .nowLvl(nowLvl), .prevLvl(prevLvl)
  );

  assign fallV = prevLvl & ~nowLvl;
  assign riseV = ~prevLvl & nowLvl;

  fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrFall(fallV[S_WR]), .wrRise(riseV[S_WR]),
    .rdFall(fallV[S_RD]), .rdRise(riseV[S_RD]),
    .rtFall(fallV[S_RT]),
    .ctl(ctl), .emptyN(emptyN), .halfN(halfN), .fullN(fullN),
    .dValid(dValid), .strobeErr(strobeErr)
  );

  fifo_rt_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .rstN(rstN), .dIn(dIn), .ctl(ctl), .dOut(dOut)
  );

  logic unusedRtRise;
  assign unusedRtRise = riseV[S_RT];
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] dOut,
  input logic             dValid,
  input logic             emptyN,
  input logic             halfN,
  input logic             fullN,
  input logic             strobeErr
);
  // R9: the error flag never clears without reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    strobeErr |=> strobeErr);

  // R6: a full buffer cannot also report empty
  a_r6_full_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    !fullN |-> emptyN);

  // R7: full always implies more than half full
  a_r7_full_implies_half: assert property (@(posedge clk) disable iff (!rstN)
    !fullN |-> !halfN);

  // R5: an empty buffer is never above half
  a_r5_empty_not_half: assert property (@(posedge clk) disable iff (!rstN)
    !emptyN |-> halfN);

  // R4: read data stays put while the read strobe is held
  a_r4_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && $past(dValid)) |-> $stable(dOut));
endmodule

bind fifo_rt fifo_rt_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .dOut(dOut), .dValid(dValid), .emptyN(emptyN),
  .halfN(halfN), .fullN(fullN), .strobeErr(strobeErr)
);

// File: tb/fifo_rt_tb.sv
`timescale 1ns/1ps
module fifo_rt_tb;
  localparam int DEPTH = 256;
  localparam int WIDTH = 9;
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrN = 1'b1, rdN = 1'b1, rtN = 1'b1;
  logic [WIDTH-1:0] dIn = '0;
  logic [WIDTH-1:0] dOut;
  logic dValid, emptyN, halfN, fullN, strobeErr;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fifo_rt #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rtN(rtN), .dIn(dIn),
    .dOut(dOut), .dValid(dValid), .emptyN(emptyN), .halfN(halfN),
    .fullN(fullN), .strobeErr(strobeErr)
  );

  // ---------------- behavioural reference model ----------------
  bit mWrS, mWrP, mRdS, mRdP, mRtS, mRtP;
  logic [WIDTH-1:0] mDS, mOut;
  logic [WIDTH-1:0] hist [$];
  int rdIdx;
  bit wrPend, rdPend, mEmptyN, mHalfN, mFullN, mErr;

  always @(posedge clk) begin
    if (!rstN) begin
      mWrS = 1; mWrP = 1; mRdS = 1; mRdP = 1; mRtS = 1; mRtP = 1;
      mDS = '0; mOut = '0; hist.delete(); rdIdx = 0;
      wrPend = 0; rdPend = 0; mEmptyN = 0; mHalfN = 1; mFullN = 1; mErr = 0;
    end else begin : model_step
      bit wf, wr, rf, rr, tf, wAcc, rAcc, wCom, rDone;
      int occ;
      wf = mWrP && !mWrS; wr = !mWrP && mWrS;
      rf = mRdP && !mRdS; rr = !mRdP && mRdS;
      tf = mRtP && !mRtS;
      wAcc  = wf && mFullN;
      rAcc  = rf && mEmptyN && !tf;
      wCom  = wr && wrPend;
      rDone = rr && rdPend;
      if (wf && !mFullN) mErr = 1;
      if (rf && !mEmptyN && !tf) mErr = 1;
      if (wCom) hist.push_back(mDS);
      if (rAcc) begin mOut = hist[rdIdx]; rdIdx++; end
      if (tf) rdIdx = 0;
      if (wAcc) wrPend = 1; else if (wr) wrPend = 0;
      if (rAcc) rdPend = 1; else if (rr) rdPend = 0;
      occ = hist.size() - rdIdx + int'(wrPend);
      mEmptyN = (hist.size() - rdIdx) != 0;
      if (tf) begin
        mFullN = (occ != DEPTH);
        mHalfN = !(occ > HALF);
      end else begin
        if (wAcc && occ == DEPTH) mFullN = 0;
        else if (rDone) mFullN = 1;
        if (wAcc && occ > HALF) mHalfN = 0;
        else if (rDone && occ <= HALF) mHalfN = 1;
      end
      mWrP = mWrS; mWrS = wrN;
      mRdP = mRdS; mRdS = rdN;
      mRtP = mRtS; mRtS = rtN;
      mDS = dIn;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(dOut == mOut, "R4", "dOut", int'(dOut), int'(mOut));
      check(dValid == rdPend, "R4", "dValid", int'(dValid), int'(rdPend));
      check(emptyN == mEmptyN, "R5", "emptyN", int'(emptyN), int'(mEmptyN));
      check(fullN == mFullN, "R6", "fullN", int'(fullN), int'(mFullN));
      check(halfN == mHalfN, "R7", "halfN", int'(halfN), int'(mHalfN));
      check(strobeErr == mErr, "R9", "strobeErr", int'(strobeErr), int'(mErr));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [WIDTH-1:0] pat(input int i);
    return WIDTH'((i * 37 + 11) % 512);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; wrN = 1'b1; rdN = 1'b1; rtN = 1'b1;
    tick(3);
    rstN = 1'b1;
    tick(1);
  endtask

  // junk on dIn at the fall, the real word only before the rise (R3)
  task automatic writeWord(input logic [WIDTH-1:0] d);
    wrN = 1'b0; dIn = ~d;
    tick(2);
    dIn = d;
    tick(1);
    wrN = 1'b1;
    tick(2);
  endtask

  task automatic readWord(input logic [WIDTH-1:0] exp, input string req);
    rdN = 1'b0;
    tick(3);
    check(dOut == exp, req, "read word", int'(dOut), int'(exp));
    check(dValid == 1'b1, "R4", "dValid during read", int'(dValid), 1);
    rdN = 1'b1;
    tick(2);
  endtask

  task automatic bothWord(input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] exp,
                          input string req);
    wrN = 1'b0; rdN = 1'b0; dIn = d;
    tick(3);
    check(dOut == exp, req, "concurrent read", int'(dOut), int'(exp));
    wrN = 1'b1; rdN = 1'b1;
    tick(2);
  endtask

  task automatic retransmit();
    rtN = 1'b0;
    tick(2);
    rtN = 1'b1;
    tick(2);
  endtask

  initial begin
    tick(1);
    doReset();
    // R1 reset state
    check(emptyN == 1'b0, "R1", "emptyN after reset", int'(emptyN), 0);
    check(halfN == 1'b1, "R1", "halfN after reset", int'(halfN), 1);
    check(fullN == 1'b1, "R1", "fullN after reset", int'(fullN), 1);
    check(dValid == 1'b0, "R1", "dValid after reset", int'(dValid), 0);
    check(strobeErr == 1'b0, "R1", "strobeErr after reset", int'(strobeErr), 0);
    check(dOut == '0, "R1", "dOut after reset", int'(dOut), 0);

    // R2, R3: order and capture on the rise
    for (int i = 0; i < 3; i++) writeWord(pat(i));
    check(emptyN == 1'b1, "R5", "emptyN after writes", int'(emptyN), 1);
    for (int i = 0; i < 3; i++) readWord(pat(i), "R3");
    check(emptyN == 1'b0, "R5", "emptyN after drain", int'(emptyN), 0);

    // R8, R9: read from empty
    rdN = 1'b0;
    tick(3);
    check(dOut == pat(2), "R8", "dOut after empty read", int'(dOut), int'(pat(2)));
    check(dValid == 1'b0, "R8", "dValid on empty read", int'(dValid), 0);
    check(strobeErr == 1'b1, "R9", "strobeErr set", int'(strobeErr), 1);
    rdN = 1'b1;
    tick(6);
    check(strobeErr == 1'b1, "R9", "strobeErr held", int'(strobeErr), 1);

    doReset();
    check(strobeErr == 1'b0, "R9", "strobeErr cleared by reset", int'(strobeErr), 0);

    // fill to full, crossing the half threshold (R6, R7)
    for (int i = 0; i < DEPTH; i++) begin
      writeWord(pat(i));
      if (i == HALF - 1) check(halfN == 1'b1, "R7", "halfN at half", int'(halfN), 1);
      if (i == HALF)     check(halfN == 1'b0, "R7", "halfN above half", int'(halfN), 0);
    end
    check(fullN == 1'b0, "R6", "fullN when full", int'(fullN), 0);

    // R8: write into a full buffer is dropped
    writeWord(9'h155);
    check(strobeErr == 1'b1, "R8", "strobeErr on full write", int'(strobeErr), 1);
    check(fullN == 1'b0, "R8", "fullN after dropped write", int'(fullN), 0);

    for (int i = 0; i < 5; i++) begin
      readWord(pat(i), "R2");
      if (i == 0) check(fullN == 1'b1, "R6", "fullN after read rise", int'(fullN), 1);
    end

    // R10: rewind and read everything again
    retransmit();
    check(fullN == 1'b0, "R10", "fullN after rewind", int'(fullN), 0);
    check(halfN == 1'b0, "R10", "halfN after rewind", int'(halfN), 0);
    check(emptyN == 1'b1, "R10", "emptyN after rewind", int'(emptyN), 1);
    for (int i = 0; i < DEPTH; i++) begin
      readWord(pat(i), "R10");
      if (DEPTH - 1 - i == HALF + 1)
        check(halfN == 1'b0, "R7", "halfN one above half", int'(halfN), 0);
      if (DEPTH - 1 - i == HALF)
        check(halfN == 1'b1, "R7", "halfN back at half", int'(halfN), 1);
    end
    check(emptyN == 1'b0, "R8", "dropped word not stored", int'(emptyN), 0);

    // R11, R12: concurrent streaming round the ring
    doReset();
    writeWord(pat(0));
    writeWord(pat(1));
    for (int k = 0; k < 2 * DEPTH + 7; k++)
      bothWord(pat(k + 2), pat(k), (k >= DEPTH) ? "R11" : "R12");
    readWord(pat(2 * DEPTH + 7), "R11");
    readWord(pat(2 * DEPTH + 8), "R11");
    check(emptyN == 1'b0, "R12", "emptyN after stream", int'(emptyN), 0);
    check(strobeErr == 1'b0, "R12", "no error during stream", int'(strobeErr), 0);

    tick(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule